// File: doc/BRIEF.md
# Burst Column Sequencer

This block walks the column order of one memory burst, one beat per enabled clock. A burst opens with a start pulse that carries a start column, a burst-length code, a burst-order bit, a write flag and a single-write option; from then on the block presents the column of the current beat together with a flag that marks the final beat. The same logic can sit inside a behavioural memory model or inside a memory controller that must track which column the device is serving.

Two column orders are available. The linear order counts upward but stays inside the aligned group of columns that the burst length defines. The interleaved order XORs the beat number into the low bits of the start column. A page-length burst walks the whole row and wraps past its last column. It carries on until a stop input ends it. A clock-enable input freezes the sequence, and a new start pulse replaces any burst already in flight.

Top module: `burst_colgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `active`=0, `last`=0, `col_out`=0.
- R2: `bl_code` sets the burst length: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=full page. The codes 3'b100, 3'b101 and 3'b110 give a single beat.
- R3: With `interleave`=0 and a fixed length L, beat k shows the start column with its low log2(L) bits replaced by (start column + k) mod L. The columns therefore stay inside the aligned block of L columns.
- R4: With `interleave`=1 and a fixed length L, beat k shows the start column with its low log2(L) bits XORed with k.
- R5: A full-page burst shows (start column + k) mod 2^COL_W on beat k. It never sets `last` and stays active until `stop` ends it.
- R6: A full-page burst with `interleave`=1 follows the linear order of R5.
- R7: When a burst starts with `is_write`=1 and `wr_single`=1, it has exactly one beat, whatever `bl_code` says. When `is_write`=0, `wr_single` has no effect.
- R8: `start` at an enabled edge loads a new burst at beat 0 from `start_col`, cutting short any running burst. It takes priority over `stop` at the same edge.
- R9: At an edge with `ce`=0, nothing changes: `col_out`, `last` and `active` keep their values, and `start` and `stop` are ignored.
- R10: `last` is high only on the final beat of a fixed-length burst. The enabled edge after that beat, or an enabled edge with `stop`=1, makes the block idle.
- R11: While idle, `col_out` is 0 and `last` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; when low the sequence holds |
| start | input | 1 | Begins a new burst at this edge |
| is_write | input | 1 | The burst being started is a write |
| bl_code | input | 3 | Burst-length code, sampled at start |
| interleave | input | 1 | 1 = interleaved order, 0 = linear order |
| wr_single | input | 1 | Makes write bursts a single beat |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Ends the running burst |
| col_out | output | COL_W | Column of the current beat |
| active | output | 1 | A burst is in progress |
| last | output | 1 | The current beat is the final one |

## Verification
Directed bursts pit the linear order against the interleaved order from start columns in the middle of a block. Only a wrap inside the block separates linear order from a plain increment, and only the beat order separates XOR from addition. Full-page runs are started next to the top of the row, so a wrap of the whole row and a missing `last` can be seen; run with the interleave bit set, they show that the page mode falls back to linear order. Single-write, reserved codes, clock-enable gaps, restarts and start-with-stop are each driven on their own. After that, a fixed-seed random mix of all inputs is checked beat by beat against a bench model of the column functions.

// File: rtl/burst_colgen_pkg.sv
// Shared types for the burst column sequencer.
// Assumes at most an 8-beat fixed burst (2-bit log length).
package burst_colgen_pkg;

    typedef struct packed {
        logic       full;   // run until stopped
        logic       il;     // XOR order
        logic [1:0] lg;     // log2 of fixed length
    } burst_cfg_t;

    // Turn the sampled mode inputs into a burst configuration.
    function automatic burst_cfg_t decode_cfg(input logic [2:0] code,
                                              input logic       il,
                                              input logic       wr,
                                              input logic       single);
        burst_cfg_t c;
        c.full = 1'b0;
        c.il   = il;
        c.lg   = 2'd0;
        if (wr && single) begin
            c.il = 1'b0;
        end else begin
            case (code)
                3'b000:  c.lg = 2'd0;
                3'b001:  c.lg = 2'd1;
                3'b010:  c.lg = 2'd2;
                3'b011:  c.lg = 2'd3;
                3'b111:  begin c.full = 1'b1; c.il = 1'b0; end
                default: c.lg = 2'd0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
// Holds the configuration and start column of the current burst.
// Assumes load is already qualified with the clock enable.
module burst_mode_reg
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  burst_cfg_t       cfg_d,
    input  logic [COL_W-1:0] base_d,
    output burst_cfg_t       cfg_q,
    output logic [COL_W-1:0] base_q
);

    // Capture the mode and start column when a burst is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            base_q <= '0;
        end else if (load) begin
            cfg_q  <= cfg_d;
            base_q <= base_d;
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter: tracks the beat index and whether a burst is running.
// Assumes mask has ones in the bits the burst walks (all ones in page mode).
module burst_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             load,
    input  logic             stop,
    input  logic             full,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] beat,
    output logic             active,
    output logic             last
);

    // The final beat is the one whose index fills the mask; page mode has none.
    always_comb begin
        last = active && !full && (beat == mask);
    end

    // Advance, restart or end the burst on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (ce) begin
            if (load) begin
                active <= 1'b1;
                beat   <= '0;
            end else if (active) begin
                if (stop || last) begin
                    active <= 1'b0;
                    beat   <= '0;
                end else begin
                    beat <= beat + COL_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/burst_col_map.sv
// Maps start column and beat index to the column of the beat.
// Bits outside the mask come from the start column; bits inside come from
// either the sum (linear order) or the XOR (interleaved order).
module burst_col_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             il,
    input  logic             active,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] mapped;

    // Linear candidate: low bits of the sum depend only on low bits of inputs.
    always_comb begin
        sum = base + beat;
    end

    // Per-bit choice between kept, summed and XORed bit.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask[i])
                mapped[i] = base[i];
            else if (il)
                mapped[i] = base[i] ^ beat[i];
            else
                mapped[i] = sum[i];
        end
    end

    // Idle shows column zero.
    always_comb begin
        col = active ? mapped : '0;
    end

endmodule

// File: rtl/burst_colgen.sv
// Burst column sequencer top. Samples the mode at each start pulse and then
// produces one column per enabled clock in linear, interleaved or page order.
// Assumes COL_W >= 3 so an 8-beat block fits in a row.
module burst_colgen
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    input  logic             is_write,
    input  logic [2:0]       bl_code,
    input  logic             interleave,
    input  logic             wr_single,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             active,
    output logic             last
);

    localparam logic [COL_W-1:0] ONE_C = COL_W'(1);

    logic             load;
    burst_cfg_t       cfg_d;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] beat;

    // A start counts only on an enabled edge.
    always_comb begin
        load  = ce && start;
        cfg_d = decode_cfg(bl_code, interleave, is_write, wr_single);
    end

    // Bits walked by the burst: the whole row in page mode.
    always_comb begin
        mask = cfg_q.full ? '1 : ((ONE_C << cfg_q.lg) - ONE_C);
    end

    burst_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .cfg_d  (cfg_d),
        .base_d (start_col),
        .cfg_q  (cfg_q),
        .base_q (base_q)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce),
        .load   (load),
        .stop   (stop),
        .full   (cfg_q.full),
        .mask   (mask),
        .beat   (beat),
        .active (active),
        .last   (last)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base   (base_q),
        .beat   (beat),
        .mask   (mask),
        .il     (cfg_q.il),
        .active (active),
        .col    (col_out)
    );

endmodule

// File: rtl/burst_colgen_chk.sv
// Checker for the burst column sequencer, attached by bind.
module burst_colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] col_out,
    input logic             active,
    input logic             last
);

    // R9
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(col_out) && $stable(active) && $stable(last)));

    // R8
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && start) |=> active);

    // R10
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && stop && !start) |=> !active);

    // R10
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && last && !start) |=> !active);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (col_out == '0 && !last));

    // R3
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && active && !start && !stop && !last) |=> (active && !$stable(col_out)));

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_colgen_bench.sv
`timescale 1ns/1ps
module burst_colgen_bench;

    localparam int COL_W = 9;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce = 1'b0;
    logic             start = 1'b0;
    logic             is_write = 1'b0;
    logic [2:0]       bl_code = 3'b000;
    logic             interleave = 1'b0;
    logic             wr_single = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             active;
    logic             last;

    int n_cmp = 0;
    int n_bad = 0;

    // model of the requirements
    bit m_act = 0;
    int m_base = 0, m_k = 0, m_len = 1;
    bit m_full = 0, m_il = 0;

    always #10 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) u_burst_colgen (.*);

    function automatic int len_of(input logic [2:0] code, input bit wr, input bit sg);
        if (wr && sg) return 1;
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col();
        if (!m_act) return 0;
        if (m_full) return (m_base + m_k) % PAGE;
        if (m_il) return m_base ^ m_k;
        return (m_base & ~(m_len - 1)) | ((m_base + m_k) & (m_len - 1));
    endfunction

    function automatic bit exp_last();
        return m_act && !m_full && (m_k == m_len - 1);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One clock: drive inputs, update model at the edge, compare after it.
    task automatic step(input bit c, input bit s, input bit st, input bit wr,
                        input logic [2:0] code, input bit il, input bit sg,
                        input int col, input string tag);
        ce = c; start = s; stop = st; is_write = wr; bl_code = code;
        interleave = il; wr_single = sg; start_col = COL_W'(col);
        @(posedge clk);
        if (c) begin
            if (s) begin
                m_act = 1; m_k = 0; m_base = col;
                m_full = (code == 3'b111) && !(wr && sg);
                m_len = len_of(code, wr, sg);
                m_il = il && !m_full && !(wr && sg);
            end else if (m_act) begin
                if (st || exp_last()) begin m_act = 0; m_k = 0; end
                else m_k = m_k + 1;
            end
        end
        #1;
        chk({tag, " col"}, int'(col_out), exp_col());
        chk({tag, " last"}, int'(last), int'(exp_last()));
        chk({tag, " active"}, int'(active), int'(m_act));
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 3'b000, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        // R1 R11 reset state
        chk("R1 col", int'(col_out), 0);
        chk("R1 active", int'(active), 0);
        chk("R11 last", int'(last), 0);
        rst_n = 1'b1;

        // R3 linear BL8 from 13: 13,14,15,8..12
        step(1, 1, 0, 0, 3'b011, 0, 0, 13, "R3");
        chk("R3 first", int'(col_out), 13);
        step(1, 0, 0, 0, 3'b000, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 3'b000, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 3'b000, 0, 0, 0, "R3");
        chk("R3 wrap", int'(col_out), 8);
        run(4, "R3");
        chk("R10 final col", int'(col_out), 12);
        chk("R10 final last", int'(last), 1);
        run(1, "R10");
        chk("R11 idle col", int'(col_out), 0);

        // R4 interleaved BL4 from 6: 6,7,4,5
        step(1, 1, 0, 0, 3'b010, 1, 0, 6, "R4");
        run(1, "R4");
        chk("R4 beat1", int'(col_out), 7);
        run(1, "R4");
        chk("R4 beat2", int'(col_out), 4);
        run(2, "R4");

        // R5 full page from 510, wraps over row end
        step(1, 1, 0, 0, 3'b111, 0, 0, 510, "R5");
        run(2, "R5");
        chk("R5 wrap", int'(col_out), 0);
        run(600, "R5");
        chk("R5 still active", int'(active), 1);
        step(1, 0, 1, 0, 3'b000, 0, 0, 0, "R5 stop");

        // R6 page with interleave bit behaves linearly
        step(1, 1, 0, 0, 3'b111, 1, 0, 3, "R6");
        run(3, "R6");
        chk("R6 linear", int'(col_out), 6);
        step(1, 0, 1, 0, 3'b000, 0, 0, 0, "R6");

        // R7 single-write forces one beat; read ignores it
        step(1, 1, 0, 1, 3'b011, 0, 1, 40, "R7 write");
        chk("R7 write last", int'(last), 1);
        run(1, "R7");
        step(1, 1, 0, 0, 3'b001, 0, 1, 41, "R7 read");
        chk("R7 read not last", int'(last), 0);
        run(2, "R7");
        step(1, 1, 0, 1, 3'b111, 0, 1, 90, "R7 write page");
        run(1, "R7");

        // R2 reserved codes give a single beat
        step(1, 1, 0, 0, 3'b101, 0, 0, 77, "R2 reserved");
        chk("R2 reserved last", int'(last), 1);
        run(1, "R2");
        step(1, 1, 0, 0, 3'b000, 1, 0, 5, "R2 bl1");
        run(1, "R2");

        // R8 restart mid-burst, and start beating stop
        step(1, 1, 0, 0, 3'b011, 0, 0, 100, "R8");
        run(2, "R8");
        step(1, 1, 0, 0, 3'b010, 1, 0, 200, "R8 restart");
        chk("R8 restart col", int'(col_out), 200);
        step(1, 1, 1, 0, 3'b001, 0, 0, 33, "R8 start+stop");
        chk("R8 start wins", int'(active), 1);
        run(2, "R8");

        // R9 ce low freezes, ignores start and stop
        step(1, 1, 0, 0, 3'b011, 0, 0, 20, "R9");
        run(1, "R9");
        step(0, 1, 1, 0, 3'b000, 0, 0, 300, "R9 frozen");
        chk("R9 held col", int'(col_out), 21);
        step(0, 0, 0, 0, 3'b000, 0, 0, 0, "R9 frozen");
        run(7, "R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] code;
            int r;
            r = $urandom_range(0, 9);
            code = (r < 7) ? 3'(r % 4) : ((r == 7) ? 3'b111 : 3'($urandom_range(4, 6)));
            step($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 2,
                 $urandom_range(0, 19) < 1, $urandom_range(0, 1) == 1, code,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                 int'($urandom_range(0, PAGE - 1)), "R3 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule